// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block maps a 32-bit local-bus address onto a PCI bus address and a PCI cycle type. It holds three programmable windows, each made of a base register and a map register. A window claims an address when it is enabled and the address bits above the window's size equal the window's base. Windows are tested in a fixed order, lowest index first, and the first enabled window that matches supplies the upper PCI address bits and the cycle type. Windows 0 and 1 are general windows whose size is a power of two from 1 MB to 2 GB. Window 2 is a fixed 16 MB window for PCI I/O space.

Windows may overlap. Software relies on this: it can enlarge window 0 so that it hides window 1, then reprogram window 1 as a configuration window without disturbing memory traffic. The map register's cycle-type field turns a general window into a memory, burst-memory, configuration, I/O or interrupt-acknowledge window. For configuration windows, a low-address flag selects whether PCI address bits 1:0 are forced to zero or taken from the local address.

Each request is translated with a registered, one-cycle latency. An address that no enabled window claims reports a miss and sets a sticky error flag, which software clears through the register port.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset, every register reads zero, no window is enabled, `rsp_valid` and `miss_err` are 0, and any request misses.
- R2: A write through the register port takes effect on the next clock, and a read returns the current value combinationally. Select codes are: 0 window-0 base, 1 window-0 map, 2 window-1 base, 3 window-1 map, 4 window-2 base, 5 window-2 map, 6 error flag. In a general base register, bits 31:20 hold the local base, bits 9:8 a stored swap mode, bits 7:4 the size code, bit 3 the prefetchable flag and bit 0 the enable. The other bits read 0.
- R3: The size code n selects a window of 2^(20+n) bytes. Codes above 11 act as 11, which gives 2 GB. Only the address bits at and above position 20+n are compared with the base.
- R4: The translated address takes bits at and above position 20+n from the map address (map bits 15:4 give PCI bits 31:20) and the bits below from the local address.
- R5: When more than one enabled window matches, the lowest index wins. A larger window 0 therefore hides window 1 and window 2.
- R6: For windows 0 and 1, `rsp_cycle` is map bits 3:1, using 000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration and 110 burst memory. `rsp_prefetch` is base bit 3. Window 2 is 16 MB, with its base in bits 15:8 of its base register (local bits 31:24), its enable in bit 0, and its map in bits 15:8 (PCI bits 31:24). Its responses have cycle type 001 and are not prefetchable.
- R7: On a window whose cycle type is 101 and whose map bit 0 is 0, PCI address bits 1:0 are 00. When map bit 0 is 1, those bits pass through from the local address.
- R8: On a miss, `rsp_hit`, `rsp_win`, `rsp_addr`, `rsp_cycle` and `rsp_prefetch` are 0 and `miss_err` becomes 1 and stays 1. A write to select 6 with bit 0 at 0 clears it, and a write with bit 0 at 1 leaves it unchanged. A miss in the same cycle as a clear keeps it set.
- R9: `rsp_valid` is 1 exactly one cycle after `req_valid` is 1, and the response fields belong to that request. Without a request, all response fields are 0.
- R10: A window with its enable bit at 0 never matches, whatever its base and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local-bus address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | A window claimed the address |
| rsp_win | output | 2 | Index of the winning window |
| rsp_addr | output | 32 | Translated PCI address |
| rsp_cycle | output | 3 | PCI cycle type |
| rsp_prefetch | output | 1 | Winning window is prefetchable |
| miss_err | output | 1 | Sticky flag set by a request that missed |

## Verification
The assertions check several rules on every cycle: the response strobe follows the request strobe by exactly one cycle, a miss response zeroes the index and raises the error flag, the flag stays set until a clearing write, and a window-2 hit always carries the I/O cycle type without prefetch. The scenarios in the bench cover the rest. These include the size boundaries, the clamping of size codes, address splicing, hiding overlapped windows by enlarging window 0, and the two configuration low-bit modes. They also cover the register layouts on readback. In each case the bench compares the response with a reference model fed from its own copy of the register writes.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 20;
    localparam int HI_W       = ADDR_W - PAGE_SHIFT;
    localparam int MAX_CODE   = 11;
    localparam int IO_CODE    = 4;
    localparam int NWIN       = 3;
    localparam int NGEN       = 2;
    localparam int IDX_W      = $clog2(NWIN);
    localparam int SEL_W      = 3;

    localparam logic [2:0] CYC_IACK = 3'b000;
    localparam logic [2:0] CYC_IO   = 3'b001;
    localparam logic [2:0] CYC_MEM  = 3'b011;
    localparam logic [2:0] CYC_CFG  = 3'b101;
    localparam logic [2:0] CYC_MEMM = 3'b110;

    localparam logic [SEL_W-1:0] SEL_IOB = 3'd4;
    localparam logic [SEL_W-1:0] SEL_IOM = 3'd5;
    localparam logic [SEL_W-1:0] SEL_ERR = 3'd6;

    typedef struct packed {
        logic [HI_W-1:0] base;
        logic [1:0]      swap;
        logic [3:0]      size;
        logic            pf;
        logic            en;
    } gen_base_t;

    typedef struct packed {
        logic [HI_W-1:0] addr;
        logic [2:0]      cyc;
        logic            lowen;
    } gen_map_t;

    typedef struct packed {
        logic [7:0] base;
        logic       en;
    } io_base_t;

    typedef struct packed {
        logic            en;
        logic [HI_W-1:0] base;
        logic [3:0]      size;
        logic [HI_W-1:0] map;
        logic [2:0]      cyc;
        logic            lowen;
        logic            pf;
    } win_t;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
    import xlate_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [SEL_W-1:0]       sel,
    input  logic [ADDR_W-1:0]      wdata,
    input  logic                   miss_evt,
    output logic [ADDR_W-1:0]      rdata,
    output win_t [NWIN-1:0]        win_o,
    output logic                   err_o
);
    typedef struct packed {
        gen_base_t [NGEN-1:0] gb;
        gen_map_t  [NGEN-1:0] gm;
        io_base_t             iob;
        logic [7:0]           iom;
        logic                 err;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wbits;
    assign unused_wbits = ^wdata[19:16];

    always_comb begin
        r_d = r_q;
        if (we) begin
            for (int i = 0; i < NGEN; i++) begin
                if (sel == SEL_W'(2 * i)) begin
                    r_d.gb[i].base = wdata[31:20];
                    r_d.gb[i].swap = wdata[9:8];
                    r_d.gb[i].size = wdata[7:4];
                    r_d.gb[i].pf   = wdata[3];
                    r_d.gb[i].en   = wdata[0];
                end
                if (sel == SEL_W'(2 * i + 1)) begin
                    r_d.gm[i].addr  = wdata[15:4];
                    r_d.gm[i].cyc   = wdata[3:1];
                    r_d.gm[i].lowen = wdata[0];
                end
            end
            if (sel == SEL_IOB) begin
                r_d.iob.base = wdata[15:8];
                r_d.iob.en   = wdata[0];
            end
            if (sel == SEL_IOM) begin
                r_d.iom = wdata[15:8];
            end
        end
        if (miss_evt) begin
            r_d.err = 1'b1;
        end else if (we && sel == SEL_ERR && !wdata[0]) begin
            r_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NGEN; i++) begin
            if (sel == SEL_W'(2 * i)) begin
                rdata = {r_q.gb[i].base, 10'b0, r_q.gb[i].swap, r_q.gb[i].size,
                         r_q.gb[i].pf, 2'b0, r_q.gb[i].en};
            end
            if (sel == SEL_W'(2 * i + 1)) begin
                rdata = {16'b0, r_q.gm[i].addr, r_q.gm[i].cyc, r_q.gm[i].lowen};
            end
        end
        if (sel == SEL_IOB) rdata = {16'b0, r_q.iob.base, 7'b0, r_q.iob.en};
        if (sel == SEL_IOM) rdata = {16'b0, r_q.iom, 8'b0};
        if (sel == SEL_ERR) rdata = {31'b0, r_q.err};
    end

    genvar g;
    generate
        for (g = 0; g < NGEN; g++) begin : g_gen_win
            assign win_o[g] = '{en:    r_q.gb[g].en,
                                base:  r_q.gb[g].base,
                                size:  r_q.gb[g].size,
                                map:   r_q.gm[g].addr,
                                cyc:   r_q.gm[g].cyc,
                                lowen: r_q.gm[g].lowen,
                                pf:    r_q.gb[g].pf};
        end
    endgenerate

    assign win_o[NWIN-1] = '{en:    r_q.iob.en,
                             base:  {r_q.iob.base, 4'b0},
                             size:  4'(IO_CODE),
                             map:   {r_q.iom, 4'b0},
                             cyc:   CYC_IO,
                             lowen: 1'b1,
                             pf:    1'b0};

    assign err_o = r_q.err;
endmodule

// File: rtl/xlate_match.sv
module xlate_match
    import xlate_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  win_t              w,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);
    logic [3:0]        code;
    logic [5:0]        shamt;
    logic [ADDR_W-1:0] hi_mask;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] map_full;
    logic              unused_pf;

    assign unused_pf = w.pf;

    always_comb begin
        code      = (w.size > 4'(MAX_CODE)) ? 4'(MAX_CODE) : w.size;
        shamt     = 6'(PAGE_SHIFT) + {2'b0, code};
        hi_mask   = {ADDR_W{1'b1}} << shamt;
        base_full = {w.base, {PAGE_SHIFT{1'b0}}};
        map_full  = {w.map,  {PAGE_SHIFT{1'b0}}};
        hit       = w.en && (((addr ^ base_full) & hi_mask) == '0);
        xaddr     = (map_full & hi_mask) | (addr & ~hi_mask);
        if (w.cyc == CYC_CFG && !w.lowen) begin
            xaddr[1:0] = 2'b00;
        end
    end
endmodule

// File: rtl/xlate_pick.sv
module xlate_pick
    import xlate_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [NWIN-1:0]              hit,
    input  logic [NWIN-1:0][ADDR_W-1:0]  xaddr,
    input  win_t [NWIN-1:0]              w,
    output logic                         miss_evt,
    output logic                         rsp_valid,
    output logic                         rsp_hit,
    output logic [IDX_W-1:0]             rsp_win,
    output logic [ADDR_W-1:0]            rsp_addr,
    output logic [2:0]                   rsp_cycle,
    output logic                         rsp_prefetch
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        cyc;
        logic              pf;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d       = '0;
        o_d.valid = req_valid;
        if (req_valid) begin
            for (int i = NWIN - 1; i >= 0; i--) begin
                if (hit[i]) begin
                    o_d.hit  = 1'b1;
                    o_d.idx  = IDX_W'(i);
                    o_d.addr = xaddr[i];
                    o_d.cyc  = w[i].cyc;
                    o_d.pf   = w[i].pf;
                end
            end
        end
        miss_evt = req_valid && (hit == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign rsp_valid    = o_q.valid;
    assign rsp_hit      = o_q.hit;
    assign rsp_win      = o_q.idx;
    assign rsp_addr     = o_q.addr;
    assign rsp_cycle    = o_q.cyc;
    assign rsp_prefetch = o_q.pf;
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
    import xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [SEL_W-1:0]     reg_sel,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [IDX_W-1:0]     rsp_win,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic [2:0]           rsp_cycle,
    output logic                 rsp_prefetch,
    output logic                 miss_err
);
    win_t [NWIN-1:0]             win;
    logic [NWIN-1:0]             hit;
    logic [NWIN-1:0][ADDR_W-1:0] xaddr;
    logic                        miss_evt;

    xlate_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .miss_evt (miss_evt),
        .rdata    (reg_rdata),
        .win_o    (win),
        .err_o    (miss_err)
    );

    genvar g;
    generate
        for (g = 0; g < NWIN; g++) begin : g_match
            xlate_match u_match (
                .addr  (req_addr),
                .w     (win[g]),
                .hit   (hit[g]),
                .xaddr (xaddr[g])
            );
        end
    endgenerate

    xlate_pick u_pick (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .hit          (hit),
        .xaddr        (xaddr),
        .w            (win),
        .miss_evt     (miss_evt),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_win      (rsp_win),
        .rsp_addr     (rsp_addr),
        .rsp_cycle    (rsp_cycle),
        .rsp_prefetch (rsp_prefetch)
    );
endmodule

// File: rtl/addr_window_xlate_chk.sv
module addr_window_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [1:0]  rsp_win,
    input logic [2:0]  rsp_cycle,
    input logic        rsp_prefetch,
    input logic        miss_err
);
    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8
    miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (miss_err && rsp_win == 2'd0 && rsp_cycle == 3'd0));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_err && !(reg_we && reg_sel == 3'd6 && !reg_wdata[0])) |=> miss_err);

    // R6
    io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_win == 2'd2) |-> (rsp_cycle == 3'b001 && !rsp_prefetch));

    // R5
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && rsp_win != 2'd3));
endmodule

bind addr_window_xlate addr_window_xlate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .req_valid    (req_valid),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_win      (rsp_win),
    .rsp_cycle    (rsp_cycle),
    .rsp_prefetch (rsp_prefetch),
    .miss_err     (miss_err)
);

// File: tb/addr_window_xlate_bench.sv
module addr_window_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'd0;
    logic        rsp_valid, rsp_hit, rsp_prefetch, miss_err;
    logic [1:0]  rsp_win;
    logic [31:0] rsp_addr;
    logic [2:0]  rsp_cycle;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] sh_b [2];
    logic [31:0] sh_m [2];
    logic [31:0] sh_b2, sh_m2;
    bit          sh_err;

    always #10 clk = ~clk;

    addr_window_xlate u_addr_window_xlate (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_win(rsp_win), .rsp_addr(rsp_addr), .rsp_cycle(rsp_cycle),
        .rsp_prefetch(rsp_prefetch), .miss_err(miss_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] a, output bit hit, output int idx,
                                  output logic [31:0] xa, output logic [2:0] cyc, output bit pf);
        hit = 0; idx = 0; xa = 0; cyc = 0; pf = 0;
        for (int w = 2; w >= 0; w--) begin
            bit en, le, p;
            int sz;
            logic [31:0] lb, mp, xw;
            logic [2:0] c;
            if (w < 2) begin
                int code;
                en = sh_b[w][0];
                code = int'(sh_b[w][7:4]);
                if (code > 11) code = 11;
                sz = 20 + code;
                lb = {sh_b[w][31:20], 20'b0};
                mp = {sh_m[w][15:4], 20'b0};
                c = sh_m[w][3:1];
                le = sh_m[w][0];
                p = sh_b[w][3];
            end else begin
                en = sh_b2[0];
                sz = 24;
                lb = {sh_b2[15:8], 24'b0};
                mp = {sh_m2[15:8], 24'b0};
                c = 3'b001;
                le = 1;
                p = 0;
            end
            xw = ((mp >> sz) << sz) | (a & ((32'h1 << sz) - 32'h1));
            if (c == 3'b101 && !le) xw[1:0] = 2'b00;
            if (en && ((a >> sz) == (lb >> sz))) begin
                hit = 1; idx = w; xa = xw; cyc = c; pf = p;
            end
        end
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 0;
        case (sel)
            3'd0: sh_b[0] = data & 32'hFFF003F9;
            3'd1: sh_m[0] = data & 32'h0000FFFF;
            3'd2: sh_b[1] = data & 32'hFFF003F9;
            3'd3: sh_m[1] = data & 32'h0000FFFF;
            3'd4: sh_b2   = data & 32'h0000FF01;
            3'd5: sh_m2   = data & 32'h0000FF00;
            3'd6: if (!data[0]) sh_err = 0;
            default: ;
        endcase
    endtask

    task automatic rd_chk(input logic [2:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_sel = sel;
        #2;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic req_chk(input logic [31:0] a, input string tag);
        bit h, p;
        int ix;
        logic [31:0] xa;
        logic [2:0] c;
        @(negedge clk);
        model(a, h, ix, xa, c, p);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        if (!h) sh_err = 1;
        chk(rsp_valid === 1'b1, {tag, " valid"}, 32'(rsp_valid), 1);
        chk(rsp_hit === h, {tag, " hit"}, 32'(rsp_hit), 32'(h));
        chk(rsp_win === 2'(ix), {tag, " win"}, 32'(rsp_win), 32'(ix));
        chk(rsp_addr === xa, {tag, " addr"}, rsp_addr, xa);
        chk(rsp_cycle === c, {tag, " cycle"}, 32'(rsp_cycle), 32'(c));
        chk(rsp_prefetch === p, {tag, " prefetch"}, 32'(rsp_prefetch), 32'(p));
        chk(miss_err === sh_err, {tag, " err"}, 32'(miss_err), 32'(sh_err));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_1234);
        sh_b[0] = 0; sh_b[1] = 0; sh_m[0] = 0; sh_m[1] = 0;
        sh_b2 = 0; sh_m2 = 0; sh_err = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int s = 0; s < 7; s++) rd_chk(3'(s), 32'h0, "R1 reset readback");
        chk(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
        chk(miss_err === 1'b0, "R1 miss_err", 32'(miss_err), 0);
        req_chk(32'h4000_0000, "R1 miss after reset");

        // R8 sticky flag, write 1 keeps, write 0 clears
        wr(3'd6, 32'h1);
        rd_chk(3'd6, 32'h1, "R8 write one keeps flag");
        wr(3'd6, 32'h0);
        rd_chk(3'd6, 32'h0, "R8 write zero clears flag");

        // R2 field layout on readback
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk(3'd0, 32'hFFF0_03F9, "R2 base layout");
        wr(3'd4, 32'hFFFF_FFFF);
        rd_chk(3'd4, 32'h0000_FF01, "R2 io base layout");
        wr(3'd5, 32'hFFFF_FFFF);
        rd_chk(3'd5, 32'h0000_FF00, "R2 io map layout");
        wr(3'd4, 32'h0);

        // R3 R4 window 0: 256MB memory at 0x40000000 -> 0
        wr(3'd0, 32'h4000_0081);
        wr(3'd1, 32'h0000_0006);
        req_chk(32'h4123_4567, "R4 splice w0");
        req_chk(32'h4FFF_FFFF, "R3 top of window");
        req_chk(32'h5000_0000, "R3 just above window");
        req_chk(32'h3FFF_FFFF, "R3 just below window");

        // R6 window 1 prefetchable burst memory
        wr(3'd2, 32'h5000_0089);
        wr(3'd3, 32'h0000_100C);
        req_chk(32'h5ABC_DEF0, "R6 w1 burst prefetch");

        // R5 enlarged window 0 hides window 1
        wr(3'd0, 32'h4000_0091);
        req_chk(32'h5ABC_DEF0, "R5 w0 hides w1");

        // R7 config window on w1
        wr(3'd2, 32'h6100_0041);
        wr(3'd3, 32'h0000_000A);
        req_chk(32'h6100_0803, "R7 cfg low bits forced");
        wr(3'd3, 32'h0000_000B);
        req_chk(32'h6100_0803, "R7 cfg low bits pass");

        // R6 window 2 I/O
        wr(3'd4, 32'h0000_6001);
        wr(3'd5, 32'h0000_0A00);
        req_chk(32'h6012_3456, "R6 io window");
        req_chk(32'h6100_0000, "R6 io window edge");

        // R5 R3 2GB window 0 hides w2, clamped code 15 same
        wr(3'd0, 32'h4000_00B1);
        req_chk(32'h6012_3456, "R5 2GB w0 hides io");
        wr(3'd0, 32'h4000_00F1);
        req_chk(32'h6012_3456, "R3 clamp code 15");
        req_chk(32'h8000_0000, "R3 clamp upper half");

        // R10 disabled window
        wr(3'd0, 32'h4000_00F0);
        req_chk(32'h1234_5678, "R10 disabled w0");
        wr(3'd6, 32'h0);

        // R9 no request -> no response
        @(negedge clk);
        @(negedge clk);
        chk(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R9 idle response", 32'(rsp_valid), 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            if (n % 16 == 0) begin
                for (int k = 0; k < 3; k++) wr(3'($urandom % 7), $urandom);
            end
            case ($urandom % 4)
                0: a = $urandom;
                1: a = {sh_b[0][31:20], 20'h0} + ($urandom & 32'h0FFF_FFFF);
                2: a = {sh_b[1][31:20], 20'h0} + ($urandom & 32'h03FF_FFFF);
                default: a = {sh_b2[15:8], 24'h0} + ($urandom & 32'h01FF_FFFF);
            endcase
            req_chk(a, "R4 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule